// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a host running on a single clock to an external asynchronous static RAM built from 16-bit words whose lower and upper bytes can be selected one at a time. The host hands over one access at a time through a valid/ready handshake. Each access carries a word address, a write flag, two byte-enable bits and write data. A read returns its data with a one-cycle valid strobe.

On the memory side the controller drives every control line from a register. These are the address, a chip-enable pair of opposite polarity, write enable, output enable and two active-low byte-lane selects. The bidirectional data pins are split into an output value, an output-enable and an input value, so the pad ring can build the tri-state buffer. Every analog timing figure is a nanosecond parameter. The controller converts each one into a whole number of clock cycles, rounding up, with a floor of one.

For a read, the controller turns on the memory's output drivers. For a write, it turns on its own data drivers. Between the two it waits long enough that both sides never drive the shared pins at the same time. It also keeps the memory deselected whenever no access is in progress, so the memory can fall back to its low-power standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, the outputs are: memory deselected (`mem_ce1_n`=1, `mem_ce2`=0), `mem_we_n`=1, `mem_oe_n`=1, both lane selects high, `mem_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: Whenever `req_ready` is high, the memory is deselected and `mem_dq_oe` is 0.
- R3: A read keeps the chip selected, `mem_oe_n` low, `mem_we_n` high, and address and lanes unchanged for ACC = ceil(max(T_ACC_NS, T_OE_NS)/CLK_PERIOD_NS) cycles (min 1) before the memory data is registered. The read data and `rsp_valid` appear ACC+1 cycles after the accepting clock edge; with the defaults that is 15 cycles.
- R4: `req_be[0]` selects the low lane (`mem_lb_n`=0, data bits 7..0), and `req_be[1]` selects the high lane (`mem_ub_n`=0, bits 15..8). A write changes only the enabled bytes. In read data, the bytes of lanes that were not enabled read as 0.
- R5: An access with `req_be`=00 transfers no data. A write leaves the stored word unchanged, and a read returns 0.
- R6: At least one cycle before `mem_we_n` falls, the address, lane selects and `mem_dq_out` already hold their write values and `mem_dq_oe` is 1.
- R7: `mem_we_n` stays low for at least WP = ceil(T_WP_NS/CLK_PERIOD_NS) cycles. Address, lanes, data and `mem_dq_oe` are held for one cycle after it rises.
- R8: `mem_oe_n` is high for every cycle in which `mem_we_n` is low.
- R9: `mem_dq_oe` stays 0 for at least HIZ = ceil(T_HIZ_NS/CLK_PERIOD_NS) cycles after `mem_oe_n` rises, and is never 1 while `mem_oe_n` is low.
- R10: `req_ready` drops on the cycle after an accepted request and returns high only when the access, including turnaround, has finished. `rsp_valid` is high for exactly one cycle per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host presents an access |
| req_ready | output | 1 | Controller can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle strobe, read data valid |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low byte lane select, active low |
| mem_ub_n | output | 1 | High byte lane select, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enables the controller's data drivers |
| mem_dq_in | input | 16 | Data received from the memory pins |

## Verification
The hardest case to reach is the moment a write follows a read immediately, while the memory may still be driving the bus as its outputs turn off. The bench's memory model holds its "still driving" state for HIZ cycles after output enable rises, and it flags any controller drive inside that window. Random read/write sequences with no idle gap between requests reach this case many times. The same model returns garbage until a read has stayed stable for the full access time, so a capture that comes too early shows up as wrong data. Directed partial-lane and empty-lane accesses to a shared address check that only the enabled bytes are merged.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_ACCESS,
        ST_READ_CAPTURE,
        ST_WRITE_SETUP,
        ST_WRITE_PULSE,
        ST_WRITE_RECOVER,
        ST_TURNAROUND
    } ctrl_state_e;

    // Whole clock cycles covering a delay in ns, never below one.
    function automatic int ns_to_cycles(input int delay_ns, input int period_ns);
        int c;
        c = (delay_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_lanes.sv
module sram_ctrl_lanes #(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic [LANES-1:0]  be,
    output logic [LANES-1:0]  sel_n,
    input  logic [LANES-1:0]  act_n,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] masked
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign sel_n[g]            = ~be[g];
        assign masked[g*8 +: 8]    = act_n[g] ? 8'h00 : raw[g*8 +: 8];
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_ACC_NS      = 55,
    parameter int T_OE_NS       = 30,
    parameter int T_WP_NS       = 40,
    parameter int T_HIZ_NS      = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int LANES   = DATA_W / 8;
    localparam int ACC_CYC = ns_to_cycles(max_of(T_ACC_NS, T_OE_NS), CLK_PERIOD_NS);
    localparam int WP_CYC  = ns_to_cycles(T_WP_NS, CLK_PERIOD_NS);
    localparam int HIZ_CYC = ns_to_cycles(T_HIZ_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC = max_of(ACC_CYC, max_of(WP_CYC, HIZ_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

    typedef struct packed {
        ctrl_state_e       state;
        logic              ready;
        logic              rsp_valid;
        logic [DATA_W-1:0] rdata;
        logic [ADDR_W-1:0] addr;
        logic              sel;
        logic              we_n;
        logic              oe_n;
        logic [LANES-1:0]  lane_n;
        logic [DATA_W-1:0] dq_out;
        logic              dq_oe;
    } ctrl_regs_t;

    localparam ctrl_regs_t REGS_RESET = '{
        state:     ST_IDLE,
        ready:     1'b1,
        rsp_valid: 1'b0,
        rdata:     '0,
        addr:      '0,
        sel:       1'b0,
        we_n:      1'b1,
        oe_n:      1'b1,
        lane_n:    '1,
        dq_out:    '0,
        dq_oe:     1'b0
    };

    ctrl_regs_t regs_d, regs_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [LANES-1:0] lane_sel_n;
    logic [DATA_W-1:0] rd_masked;

    sram_ctrl_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_ctrl_lanes #(
        .DATA_W (DATA_W)
    ) lanes_i (
        .be     (req_be),
        .sel_n  (lane_sel_n),
        .act_n  (regs_q.lane_n),
        .raw    (mem_dq_in),
        .masked (rd_masked)
    );

    always_comb begin
        regs_d           = regs_q;
        regs_d.rsp_valid = 1'b0;
        tmr_load         = 1'b0;
        tmr_val          = '0;

        unique case (regs_q.state)
            ST_IDLE: begin
                if (req_valid && regs_q.ready) begin
                    regs_d.ready  = 1'b0;
                    regs_d.addr   = req_addr;
                    regs_d.lane_n = lane_sel_n;
                    regs_d.sel    = 1'b1;
                    if (req_write) begin
                        regs_d.dq_out = req_wdata;
                        regs_d.dq_oe  = 1'b1;
                        regs_d.state  = ST_WRITE_SETUP;
                    end else begin
                        regs_d.oe_n  = 1'b0;
                        regs_d.state = ST_READ_ACCESS;
                        tmr_load     = 1'b1;
                        tmr_val      = CNT_W'(ACC_CYC - 1);
                    end
                end
            end
            ST_READ_ACCESS: begin
                if (tmr_expired) begin
                    regs_d.state = ST_READ_CAPTURE;
                end
            end
            ST_READ_CAPTURE: begin
                regs_d.rdata     = rd_masked;
                regs_d.rsp_valid = 1'b1;
                regs_d.oe_n      = 1'b1;
                regs_d.sel       = 1'b0;
                regs_d.lane_n    = '1;
                regs_d.state     = ST_TURNAROUND;
                tmr_load         = 1'b1;
                tmr_val          = CNT_W'(HIZ_CYC - 1);
            end
            ST_TURNAROUND: begin
                if (tmr_expired) begin
                    regs_d.ready = 1'b1;
                    regs_d.state = ST_IDLE;
                end
            end
            ST_WRITE_SETUP: begin
                regs_d.we_n  = 1'b0;
                regs_d.state = ST_WRITE_PULSE;
                tmr_load     = 1'b1;
                tmr_val      = CNT_W'(WP_CYC - 1);
            end
            ST_WRITE_PULSE: begin
                if (tmr_expired) begin
                    regs_d.we_n  = 1'b1;
                    regs_d.state = ST_WRITE_RECOVER;
                end
            end
            ST_WRITE_RECOVER: begin
                regs_d.sel    = 1'b0;
                regs_d.lane_n = '1;
                regs_d.dq_oe  = 1'b0;
                regs_d.ready  = 1'b1;
                regs_d.state  = ST_IDLE;
            end
            default: begin
                regs_d = REGS_RESET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= REGS_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign req_ready  = regs_q.ready;
    assign rsp_valid  = regs_q.rsp_valid;
    assign rsp_rdata  = regs_q.rdata;
    assign mem_addr   = regs_q.addr;
    assign mem_ce1_n  = ~regs_q.sel;
    assign mem_ce2    = regs_q.sel;
    assign mem_we_n   = regs_q.we_n;
    assign mem_oe_n   = regs_q.oe_n;
    assign mem_lb_n   = regs_q.lane_n[0];
    assign mem_ub_n   = regs_q.lane_n[LANES-1];
    assign mem_dq_out = regs_q.dq_out;
    assign mem_dq_oe  = regs_q.dq_oe;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 16,
    parameter int ACC_CYC = 14,
    parameter int HIZ_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    logic [15:0] oe_low_cnt;
    logic [15:0] since_oe_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_low_cnt   <= '0;
            since_oe_cnt <= '1;
        end else begin
            oe_low_cnt   <= mem_oe_n ? 16'd0 : ((oe_low_cnt == 16'hFFFF) ? oe_low_cnt : oe_low_cnt + 16'd1);
            since_oe_cnt <= !mem_oe_n ? 16'd0 : ((since_oe_cnt == 16'hFFFF) ? since_oe_cnt : since_oe_cnt + 16'd1);
        end
    end

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && !mem_ce2 && !mem_dq_oe)); // R2

    AST_READ_LONG_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (oe_low_cnt >= 16'(ACC_CYC))); // R3

    AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && $stable(mem_lb_n)
                             && $stable(mem_ub_n) && mem_dq_oe && $past(mem_dq_oe))); // R6

    AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && $stable(mem_lb_n)
                             && $stable(mem_ub_n) && mem_dq_oe)); // R7

    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R8

    AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe); // R9

    AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (since_oe_cnt >= 16'(HIZ_CYC))); // R9

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ACC_CYC (ACC_CYC),
    .HIZ_CYC (HIZ_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .mem_ce1_n  (mem_ce1_n),
    .mem_ce2    (mem_ce2),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_lb_n   (mem_lb_n),
    .mem_ub_n   (mem_ub_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

    localparam int EXP_ACC = (55 + 3) / 4;
    localparam int EXP_WP  = (40 + 3) / 4;
    localparam int EXP_HIZ = (30 + 3) / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in = 16'hDEAD;

    always #2 clk = ~clk;

    sram_async_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0;
    int n_bad = 0;
    int unsigned cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] init_word(input logic [18:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    logic [15:0] ref_mem [int unsigned];
    logic [15:0] mdl_mem [int unsigned];

    function automatic logic [15:0] ref_get(input logic [18:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_word(a);
    endfunction

    function automatic logic [15:0] mdl_get(input logic [18:0] a);
        return mdl_mem.exists(int'(a)) ? mdl_mem[int'(a)] : init_word(a);
    endfunction

    // Behavioural memory with access-time and bus-release modelling
    logic        p_sel = 1'b0, p_we_n = 1'b1, p_dq_oe = 1'b0, p_rd = 1'b0;
    logic [18:0] p_addr = '0;
    logic [1:0]  p_lanes = 2'b11;
    logic [15:0] p_dq = '0;
    logic [18:0] w_addr = '0;
    logic [1:0]  w_lanes = 2'b11;
    logic [15:0] w_data = '0;
    int          wp_cnt = 0;
    int          acc_cnt = 0;
    int          hz_cnt = 0;

    always @(negedge clk) begin
        logic       sel, rd;
        logic [1:0] lanes;
        logic [15:0] word, m;
        sel   = !mem_ce1_n && mem_ce2;
        lanes = {mem_ub_n, mem_lb_n};
        rd    = sel && !mem_oe_n && mem_we_n && (lanes != 2'b11);
        if (rst_n) begin
            if (req_ready)
                chk(mem_ce1_n && !mem_ce2 && !mem_dq_oe, "R2 idle deselect",
                    {29'd0, mem_ce1_n, mem_ce2, mem_dq_oe}, 32'h4);
            if (mem_dq_oe)
                chk(!rd && hz_cnt == 0, "R9 bus contention", hz_cnt, 0);
            if (!mem_we_n)
                chk(mem_oe_n, "R8 oe high in write", mem_oe_n, 1);
            if (p_we_n && !mem_we_n) begin
                chk(sel && p_sel && p_addr == mem_addr && p_lanes == lanes && p_dq == mem_dq_out
                    && p_dq_oe && mem_dq_oe, "R6 write setup", {p_addr, p_lanes}, {mem_addr, lanes});
                w_addr = mem_addr; w_lanes = lanes; w_data = mem_dq_out; wp_cnt = 1;
            end else if (!mem_we_n) begin
                wp_cnt++;
            end
            if (!p_we_n && mem_we_n) begin
                chk(wp_cnt >= EXP_WP, "R7 pulse width", wp_cnt, EXP_WP);
                chk(sel && mem_dq_oe && w_addr == mem_addr && w_lanes == lanes && w_data == mem_dq_out,
                    "R7 write hold", {w_addr, w_lanes}, {mem_addr, lanes});
                word = mdl_get(w_addr);
                m = lane_mask(~w_lanes);
                mdl_mem[int'(w_addr)] = (word & ~m) | (w_data & m);
            end
            if (rd && p_rd && p_addr == mem_addr && p_lanes == lanes) acc_cnt++;
            else if (rd) acc_cnt = 1;
            else acc_cnt = 0;
            if (rd && acc_cnt >= EXP_ACC) begin
                m = lane_mask(~lanes);
                mem_dq_in = (mdl_get(mem_addr) & m) | (16'hDEAD & ~m);
            end else begin
                mem_dq_in = 16'hDEAD;
            end
            if (rd) hz_cnt = EXP_HIZ;
            else if (hz_cnt > 0) hz_cnt--;
        end
        p_sel = sel; p_we_n = mem_we_n; p_dq_oe = mem_dq_oe; p_rd = rd;
        p_addr = mem_addr; p_lanes = lanes; p_dq = mem_dq_out;
    end

    task automatic txn(input bit wr, input logic [18:0] a, input logic [1:0] be, input logic [15:0] wd);
        int unsigned t0;
        int guard;
        logic [15:0] exp_d;
        string tag;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = ~wd;
        t0 = cyc;
        chk(!req_ready, "R10 ready drops", req_ready, 0);
        if (wr) begin
            ref_mem[int'(a)] = (ref_get(a) & ~lane_mask(be)) | (wd & lane_mask(be));
        end else begin
            guard = 0;
            while (!rsp_valid && guard < 100) begin
                @(negedge clk);
                guard++;
            end
            chk((cyc - t0) == EXP_ACC + 1, "R3 read latency", cyc - t0, EXP_ACC + 1);
            exp_d = ref_get(a) & lane_mask(be);
            tag = (be == 2'b00) ? "R5 empty-lane read" :
                  (be == 2'b11) ? "R3 read data" : "R4 lane read data";
            chk(rsp_rdata == exp_d, tag, rsp_rdata, exp_d);
            @(negedge clk);
            chk(!rsp_valid, "R10 valid one cycle", rsp_valid, 0);
        end
        guard = 0;
        while (!req_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(req_ready, "R10 ready returns", req_ready, 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(mem_ce1_n && !mem_ce2, "R1 reset deselect", {mem_ce1_n, mem_ce2}, 2'b10);
        chk(mem_we_n && mem_oe_n, "R1 reset we/oe", {mem_we_n, mem_oe_n}, 2'b11);
        chk(mem_lb_n && mem_ub_n && !mem_dq_oe, "R1 reset lanes", {mem_ub_n, mem_lb_n, mem_dq_oe}, 3'b110);
        chk(req_ready && !rsp_valid, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed lane and empty-lane cases
        txn(1'b1, 19'd5, 2'b11, 16'h1234);
        txn(1'b1, 19'd5, 2'b00, 16'hFFFF);            // R5 no transfer
        txn(1'b0, 19'd5, 2'b11, 16'h0);               // R5 expect 1234
        txn(1'b1, 19'd5, 2'b01, 16'hAAAA);            // R4 low lane only
        txn(1'b1, 19'd5, 2'b10, 16'hBBBB);            // R4 high lane only
        txn(1'b0, 19'd5, 2'b11, 16'h0);
        txn(1'b0, 19'd5, 2'b01, 16'h0);
        txn(1'b0, 19'd5, 2'b10, 16'h0);
        txn(1'b0, 19'd5, 2'b00, 16'h0);               // R5 read returns 0
        txn(1'b1, 19'h7FFFF, 2'b11, 16'hC0DE);        // top address
        txn(1'b0, 19'h7FFFF, 2'b11, 16'h0);
        txn(1'b0, 19'd0, 2'b11, 16'h0);               // never-written word
        txn(1'b1, 19'd0, 2'b11, 16'h0F0F);            // write right after read: R9

        // Random mix over a small address pool
        for (int i = 0; i < 300; i++) begin
            int unsigned idx;
            logic [18:0] a;
            idx = $urandom % 8;
            a = (idx == 7) ? 19'h7FFFF : 19'(idx * 32'h9A1);
            txn(1'($urandom % 2), a, 2'($urandom % 4), 16'($urandom));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule